// File: doc/BRIEF.md
# Edge-Triggered Interrupt Cause Collector

This block turns thirteen live status levels from a serial flash controller into latched interrupt causes. A cause bit is set only when its status level goes from low to high. It then stays set until software writes a one to that bit position. A separate mask word selects which causes may drive the single interrupt line. The line is high whenever any cause bit and its mask bit are both set.

Software sees the live levels and the latched causes on separate read buses. A level that is already high when its mask bit is enabled raises no interrupt, because no new rising edge occurs. The driver must therefore check the live level before it waits on the interrupt. After reset, the edge detector spends one cycle capturing the current levels before it starts comparing. This stops a level that is high at reset release from looking like an edge.

Top module: `evt_irq_collect`

## Requirements
- R1: The status, cause and mask words share one bit layout: 0 transfer done, 1 transfer ready, 2 read FIFO ready, 3 write FIFO ready, 4 read FIFO empty, 5 read FIFO full, 6 write FIFO empty, 7 write FIFO full, 8 read FIFO underflow, 9 read FIFO overflow, 10 write FIFO underflow, 11 write FIFO overflow, 12 address not configured. A rising edge on status bit k sets cause bit k, and only that bit.
- R2: A cause bit is set only on the clock edge at which its level is sampled high after being sampled low on the previous edge. A level that stays high does not set the bit again after it has been cleared.
- R3: A cause write clears each cause bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: A cause write of all ones clears every cause bit.
- R5: A new rising edge and a clearing write on the same bit in the same cycle leave the bit set.
- R6: When the mask word is all zeros, `irq` is low, whatever the causes are.
- R7: `irq` is high exactly when some cause bit and the mask bit at the same position are both 1. It follows the cause and mask registers with no extra delay.
- R8: During reset and after it, the cause and mask words read zero and `irq` is low. Levels that are already high when reset is released set no cause bit.
- R9: A mask write stores `mask_wr_data`, and `mask_rd` shows the stored value from the next cycle on.
- R10: `stat_rd` shows the live status levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_lvl | input | 13 | Live status levels, synchronous to clk |
| cause_wr_en | input | 1 | Write strobe for the cause word (write one to clear) |
| cause_wr_data | input | 13 | Cause clear bits |
| mask_wr_en | input | 1 | Write strobe for the mask word |
| mask_wr_data | input | 13 | New mask value |
| cause_rd | output | 13 | Latched cause word |
| mask_rd | output | 13 | Mask word |
| stat_rd | output | 13 | Live status readback |
| irq | output | 1 | Interrupt output |

## Verification
The assertions check on every cycle that:
- a newly set cause bit always follows a low-to-high level on the same bit;
- a clear never removes a bit that a same-cycle edge is setting;
- bits written with one are cleared unless such an edge is present;
- the mask stores what was written;
- `irq` stays low while the mask is zero, and causes stay zero until the detector has captured its first levels.

Only the bench scenarios show that a level held high through reset sets nothing, that a clear of a still-high level sticks, and that all-ones clears everything. They also compare the exact cause and `irq` values against a model over long random runs.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int STAT_W = 13;
  localparam int SYNC_STAGES = 2;
  // Bit positions shared by status, cause and mask words
  localparam int B_XFER_DONE   = 0;
  localparam int B_XFER_RDY    = 1;
  localparam int B_RF_RDY      = 2;
  localparam int B_WF_RDY      = 3;
  localparam int B_RF_EMPTY    = 4;
  localparam int B_RF_FULL     = 5;
  localparam int B_WF_EMPTY    = 6;
  localparam int B_WF_FULL     = 7;
  localparam int B_RF_UNDER    = 8;
  localparam int B_RF_OVER     = 9;
  localparam int B_WF_UNDER    = 10;
  localparam int B_WF_OVER     = 11;
  localparam int B_ADDR_NOCFG  = 12;
endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync #(
  parameter int STAGES = evt_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/evt_edge_bank.sv
module evt_edge_bank #(
  parameter int W = evt_pkg::STAT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic armed_q, armed_d;
  logic [W-1:0] prev_q;

  // First cycle after reset only captures levels
  always_comb armed_d = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic prev_d;
    always_comb prev_d = lvl_i[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= prev_d;
    end

    assign rise_o[i] = armed_q & lvl_i[i] & ~prev_q[i];
  end
endmodule

// File: rtl/evt_cause_reg.sv
module evt_cause_reg #(
  parameter int W = evt_pkg::STAT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_bits_i,
  output logic [W-1:0] cause_o
);
  logic [W-1:0] cause_q, cause_d, clr_vec;
  logic         cause_en;

  always_comb begin
    clr_vec  = clr_en_i ? clr_bits_i : '0;
    cause_en = clr_en_i | (|rise_i);
    // set has priority over clear
    cause_d  = (cause_q & ~clr_vec) | rise_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (cause_en) cause_q <= cause_d;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/evt_mask_reg.sv
module evt_mask_reg #(
  parameter int W = evt_pkg::STAT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q, mask_d;

  always_comb mask_d = wr_data_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_en_i) mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/evt_irq_collect.sv
module evt_irq_collect #(
  parameter int W = evt_pkg::STAT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat_lvl,
  input  logic         cause_wr_en,
  input  logic [W-1:0] cause_wr_data,
  input  logic         mask_wr_en,
  input  logic [W-1:0] mask_wr_data,
  output logic [W-1:0] cause_rd,
  output logic [W-1:0] mask_rd,
  output logic [W-1:0] stat_rd,
  output logic         irq
);
  logic         srst_n;
  logic [W-1:0] rise;

  evt_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  evt_edge_bank #(.W(W)) u_edge (
    .clk    (clk),
    .rst_n  (srst_n),
    .lvl_i  (stat_lvl),
    .rise_o (rise)
  );

  evt_cause_reg #(.W(W)) u_cause (
    .clk        (clk),
    .rst_n      (srst_n),
    .rise_i     (rise),
    .clr_en_i   (cause_wr_en),
    .clr_bits_i (cause_wr_data),
    .cause_o    (cause_rd)
  );

  evt_mask_reg #(.W(W)) u_mask (
    .clk       (clk),
    .rst_n     (srst_n),
    .wr_en_i   (mask_wr_en),
    .wr_data_i (mask_wr_data),
    .mask_o    (mask_rd)
  );

  assign stat_rd = stat_lvl;
  assign irq     = |(cause_rd & mask_rd);
endmodule

// File: rtl/evt_irq_collect_chk.sv
module evt_irq_collect_chk #(
  parameter int W = evt_pkg::STAT_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] stat_lvl,
  input logic         cause_wr_en,
  input logic [W-1:0] cause_wr_data,
  input logic         mask_wr_en,
  input logic [W-1:0] mask_wr_data,
  input logic [W-1:0] cause_rd,
  input logic [W-1:0] mask_rd,
  input logic [W-1:0] stat_rd,
  input logic         irq
);
  logic [1:0] settle_q;
  logic [1:0] settle_d;
  logic       settled;

  always_comb settle_d = (settle_q == 2'd3) ? settle_q : settle_q + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) settle_q <= '0;
    else        settle_q <= settle_d;
  end

  assign settled = (settle_q == 2'd3);

  assert_rise_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_rd & ~$past(cause_rd)) & ~($past(stat_lvl) & ~$past(stat_lvl, 2))) == '0);

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cause_wr_en |=> (cause_rd & $past(cause_wr_data)
                     & ~($past(stat_lvl) & ~$past(stat_lvl, 2))) == '0);

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && cause_wr_en) |=> (($past(stat_lvl) & ~$past(stat_lvl, 2)) & ~cause_rd) == '0);

  assert_mask_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_rd == '0) |-> !irq);

  assert_quiet_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !settled |-> (cause_rd == '0 && mask_rd == '0));

  assert_mask_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && mask_wr_en) |=> mask_rd == $past(mask_wr_data));
endmodule

bind evt_irq_collect evt_irq_collect_chk #(.W(W)) u_chk (.*);

// File: tb/evt_irq_collect_tb.sv
module evt_irq_collect_tb;
  localparam int W = evt_pkg::STAT_W;
  localparam logic [W-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] stat_lvl;
  logic         cause_wr_en;
  logic [W-1:0] cause_wr_data;
  logic         mask_wr_en;
  logic [W-1:0] mask_wr_data;
  logic [W-1:0] cause_rd, mask_rd, stat_rd;
  logic         irq;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [W-1:0] m_cause, m_mask, m_prev;

  always #5 clk = ~clk;

  evt_irq_collect u_dut (
    .clk(clk), .rst_n(rst_n), .stat_lvl(stat_lvl),
    .cause_wr_en(cause_wr_en), .cause_wr_data(cause_wr_data),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .cause_rd(cause_rd), .mask_rd(mask_rd), .stat_rd(stat_rd), .irq(irq)
  );

  function automatic logic [W-1:0] next_cause(logic [W-1:0] c, logic [W-1:0] lvl,
      logic [W-1:0] prv, logic clr_en, logic [W-1:0] clr);
    logic [W-1:0] rise = lvl & ~prv;
    return (c & ~(clr_en ? clr : '0)) | rise;
  endfunction

  function automatic logic exp_irq(logic [W-1:0] c, logic [W-1:0] m);
    return |(c & m);
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive at negedge, clock, compare at next negedge
  task automatic cyc(string req, logic [W-1:0] lvl, logic cwe, logic [W-1:0] cwd,
                     logic mwe, logic [W-1:0] mwd);
    stat_lvl = lvl; cause_wr_en = cwe; cause_wr_data = cwd;
    mask_wr_en = mwe; mask_wr_data = mwd;
    @(posedge clk);
    m_cause = next_cause(m_cause, lvl, m_prev, cwe, cwd);
    m_prev  = lvl;
    if (mwe) m_mask = mwd;
    @(negedge clk);
    chk(req, "cause", 16'(cause_rd), 16'(m_cause));
    chk(req, "mask",  16'(mask_rd),  16'(m_mask));
    chk("R7", "irq", 16'(irq), 16'(exp_irq(m_cause, m_mask)));
    chk("R10", "stat", 16'(stat_rd), 16'(lvl));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] lv;
    void'($urandom(32'd4711));
    rst_n = 1'b0; stat_lvl = 13'h0041; cause_wr_en = 0; cause_wr_data = '0;
    mask_wr_en = 0; mask_wr_data = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8", "cause in reset", 16'(cause_rd), 16'h0);
    chk("R8", "irq in reset", 16'(irq), 16'h0);
    rst_n = 1'b1;
    // levels held high across release; mask writes ignored during sync
    repeat (4) @(negedge clk);
    chk("R8", "cause after release", 16'(cause_rd), 16'h0);
    chk("R8", "mask after release", 16'(mask_rd), 16'h0);
    m_cause = '0; m_mask = '0; m_prev = 13'h0041;

    // R9: mask store, R6: causes with zero mask
    cyc("R9", 13'h0041, 0, '0, 1, 13'h0000);
    cyc("R1", 13'h0043, 0, '0, 0, '0);               // bit 1 rises
    chk("R1", "xfer ready only", 16'(cause_rd), 16'h0002);
    chk("R6", "irq mask zero", 16'(irq), 16'h0);
    cyc("R1", 13'h1043, 0, '0, 0, '0);               // bit 12 rises
    chk("R1", "addr bit", 16'(cause_rd), 16'h1002);
    cyc("R9", 13'h1043, 0, '0, 1, 13'h1000);
    chk("R9", "mask value", 16'(mask_rd), 16'h1000);
    chk("R7", "irq on", 16'(irq), 16'h1);
    // R3: partial clear, held level stays cleared (R2)
    cyc("R3", 13'h1043, 1, 13'h1000, 0, '0);
    chk("R3", "partial clear", 16'(cause_rd), 16'h0002);
    chk("R2", "irq after clear", 16'(irq), 16'h0);
    cyc("R2", 13'h1043, 0, '0, 0, '0);
    chk("R2", "held level no reset", 16'(cause_rd), 16'h0002);
    // R5: fall then rise with simultaneous clear
    cyc("R5", 13'h0043, 0, '0, 0, '0);
    cyc("R5", 13'h1043, 1, 13'h1000, 0, '0);
    chk("R5", "set wins", 16'(cause_rd), 16'h1002);
    // R4: clear all
    cyc("R4", 13'h1043, 1, ONES, 0, '0);
    chk("R4", "all cleared", 16'(cause_rd), 16'h0);
    cyc("R6", 13'h0000, 0, '0, 1, 13'h0000);
    cyc("R6", 13'h1FFF, 0, '0, 0, '0);
    chk("R6", "irq with zero mask", 16'(irq), 16'h0);
    cyc("R4", 13'h1FFF, 1, ONES, 0, '0);

    // random phase
    for (int n = 0; n < 400; n++) begin
      lv = stat_lvl;
      for (int b = 0; b < W; b++)
        if ($urandom_range(0, 5) == 0) lv[b] = ~lv[b];
      cyc("R2", lv, ($urandom_range(0, 3) == 0), W'($urandom),
          ($urandom_range(0, 7) == 0), W'($urandom));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule